// File: doc/BRIEF.md
# Programmable Period and Duty PWM Generator

This block turns its clock into a pulse-width-modulated output whose total period and high time are each set by an 8-bit value, with an optional halving of the counting rate. A serial write port, outside this block, assembles one, two or three bytes while it is selected. When it is deselected it gives a single-cycle load strobe, a byte count and the assembled word. A digital trip input stands in for an over-threshold comparator: it drives the output low at once and keeps it there until the trip has gone and the host writes again.

The output stays low after reset until the first three-byte configuration. After that, rewrites of the pulse width alone, of frequency plus pulse width, or of all three bytes are staged and adopted only when the running period ends. A power-down bit in the control byte stops counting. Only a three-byte write with that bit clear restarts the generator. A status flag reports whether the generator is running.

Top module: `pwm_gen`

## Requirements
- R1: While reset is asserted and after it is released, `pwm_out` and `run_flag` are 0 and no configuration is held.
- R2: The total output period is (F+1)*(D+1) clock cycles, where F is the frequency byte and D is the divide bit (bit 0 of the control byte). D=1 advances the period counter on every second cycle only.
- R3: The output is high for the first (min(P,F)+1)*(D+1) cycles of each period and low for the rest, where P is the pulse-width byte. With P >= F the output stays high for the whole period.
- R4: A write made while the generator runs does not change the period in progress. The new values govern the period that begins after the current one ends.
- R5: Until a three-byte load has been received, the output stays 0 and `run_flag` stays 0, even if one- or two-byte loads arrive.
- R6: When a load starts the generator from idle, `pwm_out` is high in the cycle after the strobe edge, and that cycle is the first of a new period using the loaded values.
- R7: While `trip_in` is 1, `pwm_out` is 0 in the same cycle. The trip is latched. The output stays 0 until a load strobe with a non-zero byte count arrives while `trip_in` is 0. That load starts a new period at once.
- R8: A three-byte load with bit 2 of the control byte set stops counting and holds the output at 0. Shorter loads do not resume it. A later three-byte load with bit 2 clear resumes it.
- R9: Encoding of `ld_kind`:
  - 3: loads control from `ld_word[23:16]`, frequency from `[15:8]` and pulse width from `[7:0]`.
  - 2: loads frequency from `[15:8]` and pulse width from `[7:0]`.
  - 1: loads pulse width from `[7:0]`.
  - 0: has no effect.
- R10: `run_flag` is 1 exactly while the generator is configured, not powered down and not tripped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that is divided into the output waveform |
| rst | input | 1 | Synchronous active-high reset |
| ld_stb | input | 1 | One-cycle strobe from the serial port at deselect |
| ld_kind | input | 2 | Number of bytes received (0 to 3) |
| ld_word | input | 24 | Assembled bytes, last byte received in bits 7:0 |
| trip_in | input | 1 | Digital over-threshold trip, active high |
| pwm_out | output | 1 | Modulated output |
| run_flag | output | 1 | Generator is running |

## Verification
A table of divide, frequency and pulse-width settings is started from reset. For each setting the bench measures the high and low run lengths. These tell apart an off-by-one in the period or high-time count and a divide bit applied to only one of the two counts. Each byte-count kind is then issued mid-period. The length of the remaining part of the current period shows whether a value was adopted too early, and the next full period shows whether it was adopted at all. Trip, power-down, pulse width at or above the frequency value, and partial loads before configuration are each driven on their own, so that each one's effect on the output is seen in isolation.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  localparam int CTRL_DIV_BIT = 0;
  localparam int CTRL_PDN_BIT = 2;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_PW   = 2'd1,
    LD_FP   = 2'd2,
    LD_ALL  = 2'd3
  } ld_kind_e;

  // output level for a counter position within the period
  function automatic logic level_at(input logic [7:0] pos, input logic [7:0] pw);
    return pos <= pw;
  endfunction

  // total period length in clock cycles
  function automatic int unsigned period_cycles(input logic [7:0] f, input logic div);
    return (int'(f) + 1) * (div ? 2 : 1);
  endfunction

  // high time in clock cycles, saturating at the period
  function automatic int unsigned high_cycles(input logic [7:0] f, input logic [7:0] p,
                                              input logic div);
    return ((p >= f) ? int'(f) + 1 : int'(p) + 1) * (div ? 2 : 1);
  endfunction

endpackage

// File: rtl/pwm_gen_cfg.sv
module pwm_gen_cfg #(
  parameter int W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_stb,
  input  pwm_gen_pkg::ld_kind_e   ld_kind,
  input  logic [3*W-1:0]          ld_word,
  input  logic                    trip_in,
  output logic [W-1:0]            sh_f_n,
  output logic [W-1:0]            sh_p_n,
  output logic                    sh_div_n,
  output logic                    run_n,
  output logic                    run_q,
  output logic                    trip_q,
  output logic                    cfg_q,
  output logic                    pdn_q
);
  import pwm_gen_pkg::*;

  logic [W-1:0] sh_f_q, sh_p_q;
  logic         sh_div_q;
  logic         cfg_n, pdn_n, trip_n;
  logic         ld_any, ld_full, ld_freq, trip_clear;

  assign ld_any     = ld_stb && (ld_kind != LD_NONE);
  assign ld_full    = ld_stb && (ld_kind == LD_ALL);
  assign ld_freq    = ld_stb && (ld_kind == LD_ALL || ld_kind == LD_FP);
  assign trip_clear = ld_any && !trip_in;

  always_comb begin
    sh_p_n   = ld_any  ? ld_word[W-1:0]   : sh_p_q;
    sh_f_n   = ld_freq ? ld_word[2*W-1:W] : sh_f_q;
    sh_div_n = ld_full ? ld_word[2*W+CTRL_DIV_BIT] : sh_div_q;
    cfg_n    = cfg_q | ld_full;
    pdn_n    = ld_full ? ld_word[2*W+CTRL_PDN_BIT] : pdn_q;
    trip_n   = (trip_in && !pdn_q) || (trip_q && !trip_clear);
    run_n    = cfg_n && !pdn_n && !trip_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_f_q   <= '0;
      sh_p_q   <= '0;
      sh_div_q <= 1'b0;
      cfg_q    <= 1'b0;
      pdn_q    <= 1'b0;
      trip_q   <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      sh_f_q   <= sh_f_n;
      sh_p_q   <= sh_p_n;
      sh_div_q <= sh_div_n;
      cfg_q    <= cfg_n;
      pdn_q    <= pdn_n;
      trip_q   <= trip_n;
      run_q    <= run_n;
    end
  end

  AST_PDN_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    (pdn_q && !ld_full) |=> pdn_q);                                   // R8
  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (trip_q && !ld_stb) |=> trip_q);                                  // R7
  AST_CFG_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q && !(ld_stb && ld_kind == LD_ALL)) |=> !cfg_q);           // R5

endmodule

// File: rtl/pwm_gen_counter.sv
module pwm_gen_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_n,
  input  logic         run_q,
  input  logic [W-1:0] sh_f_n,
  input  logic [W-1:0] sh_p_n,
  input  logic         sh_div_n,
  output logic [W-1:0] pos_q,
  output logic [W-1:0] cur_p_q,
  output logic         wrap
);
  logic [W-1:0] cur_f_q;
  logic         cur_div_q;
  logic         half_q;
  logic         tick;
  logic         start;

  assign tick  = !cur_div_q || half_q;
  assign wrap  = run_q && tick && (pos_q == cur_f_q);
  assign start = run_n && !run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      cur_f_q   <= '0;
      cur_p_q   <= '0;
      cur_div_q <= 1'b0;
      half_q    <= 1'b0;
    end else if (start || (run_n && wrap)) begin
      pos_q     <= '0;
      half_q    <= 1'b0;
      cur_f_q   <= sh_f_n;
      cur_p_q   <= sh_p_n;
      cur_div_q <= sh_div_n;
    end else if (run_n) begin
      half_q <= cur_div_q ? !half_q : 1'b0;
      if (tick) pos_q <= pos_q + 1'b1;
    end
  end

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (pos_q <= cur_f_q));                                    // R2
  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
    (run_q && !wrap) |=> ($stable(cur_f_q) && $stable(cur_p_q) && $stable(cur_div_q))); // R4
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> (pos_q == '0 && !half_q));                       // R6

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_stb,
  input  logic [1:0]     ld_kind,
  input  logic [3*W-1:0] ld_word,
  input  logic           trip_in,
  output logic           pwm_out,
  output logic           run_flag
);
  import pwm_gen_pkg::*;

  logic [W-1:0] sh_f_n, sh_p_n, pos_q, cur_p_q;
  logic         sh_div_n, run_n, run_q, trip_q, cfg_q, pdn_q, wrap;
  logic         level;

  pwm_gen_cfg #(.W(W)) u_cfg (
    .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_kind(ld_kind_e'(ld_kind)),
    .ld_word(ld_word), .trip_in(trip_in),
    .sh_f_n(sh_f_n), .sh_p_n(sh_p_n), .sh_div_n(sh_div_n),
    .run_n(run_n), .run_q(run_q), .trip_q(trip_q), .cfg_q(cfg_q), .pdn_q(pdn_q)
  );

  pwm_gen_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .run_n(run_n), .run_q(run_q),
    .sh_f_n(sh_f_n), .sh_p_n(sh_p_n), .sh_div_n(sh_div_n),
    .pos_q(pos_q), .cur_p_q(cur_p_q), .wrap(wrap)
  );

  assign level    = level_at(pos_q, cur_p_q);
  assign pwm_out  = run_q && !trip_in && level;
  assign run_flag = run_q;

  AST_IDLE_BEFORE_CFG: assert property (@(posedge clk) disable iff (rst)
    !cfg_q |-> (!pwm_out && !run_flag));                              // R5
  AST_TRIP_LOW: assert property (@(posedge clk) disable iff (rst)
    trip_in |-> !pwm_out);                                            // R7
  AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (trip_q && !ld_stb) |=> !pwm_out);                                // R7
  AST_PDN_IDLE: assert property (@(posedge clk) disable iff (rst)
    pdn_q |-> (!pwm_out && !run_flag));                               // R8
  AST_HIGH_AT_START: assert property (@(posedge clk) disable iff (rst)
    ($rose(run_flag) && !trip_in) |-> pwm_out);                       // R6

endmodule

// File: tb/pwm_gen_test.sv
module pwm_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_stb = 1'b0;
  logic [1:0]  ld_kind = 2'd0;
  logic [23:0] ld_word = '0;
  logic        trip_in = 1'b0;
  logic        pwm_out, run_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  pwm_gen uut (.clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_kind(ld_kind),
               .ld_word(ld_word), .trip_in(trip_in),
               .pwm_out(pwm_out), .run_flag(run_flag));

  always #10 clk = ~clk;

  // {div, F, P, expected high, expected low}
  localparam int VEC[7][5] = '{
    '{0, 5, 3, 4, 2},
    '{0, 4, 1, 2, 3},
    '{1, 4, 1, 4, 6},
    '{1, 3, 0, 2, 6},
    '{0, 9, 0, 1, 9},
    '{1, 7, 6, 14, 2},
    '{0, 1, 0, 1, 1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the strobe edge
  task automatic load(input logic [1:0] kind, input logic [7:0] c,
                      input logic [7:0] f, input logic [7:0] p);
    ld_stb = 1'b1; ld_kind = kind; ld_word = {c, f, p};
    @(negedge clk);
    ld_stb = 1'b0; ld_kind = 2'd0; ld_word = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    while (pwm_out === 1'b1 && hi < 600) begin hi++; @(negedge clk); end
    while (pwm_out === 1'b0 && lo < 600) begin lo++; @(negedge clk); end
  endtask

  task automatic low_for(input string req, input int n);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out !== 1'b0) highs++;
      @(negedge clk);
    end
    check(req, highs, 0);
  endtask

  initial begin
    int hi, lo;
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 pwm in reset", int'(pwm_out), 0);
    check("R1 run in reset", int'(run_flag), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pwm after reset", int'(pwm_out), 0);
    check("R10 run after reset", int'(run_flag), 0);

    // R5: partial loads before configuration
    load(2'd2, 8'h00, 8'd3, 8'd1);
    load(2'd1, 8'h00, 8'd0, 8'd1);
    check("R5 run after partial", int'(run_flag), 0);
    low_for("R5 low before full load", 10);

    // R2 R3 R6 table of settings, each from reset
    for (int v = 0; v < 7; v++) begin
      do_reset();
      load(2'd3, 8'(VEC[v][0]), 8'(VEC[v][1]), 8'(VEC[v][2]));
      check("R6 high right after start", int'(pwm_out), 1);
      measure(hi, lo);
      check("R3 high length", hi, VEC[v][3]);
      check("R2 low length", lo, VEC[v][3] + VEC[v][4] - hi);
      measure(hi, lo);
      check("R2 steady period", hi + lo, VEC[v][3] + VEC[v][4]);
    end

    // R3: P >= F keeps output high
    do_reset();
    load(2'd3, 8'h00, 8'd3, 8'd7);
    begin
      int lows = 0;
      for (int i = 0; i < 12; i++) begin
        if (pwm_out !== 1'b1) lows++;
        @(negedge clk);
      end
      check("R3 saturated high", lows, 0);
    end

    // R4 R9: mid-period rewrites
    do_reset();
    load(2'd3, 8'h00, 8'd9, 8'd4);
    load(2'd1, 8'h00, 8'd0, 8'd1);            // kind 1: pulse width only
    measure(hi, lo);
    check("R4 old high kept", hi, 4);
    check("R4 old low kept", lo, 5);
    measure(hi, lo);
    check("R9 new pw high", hi, 2);
    check("R9 new pw low", lo, 8);
    load(2'd2, 8'h00, 8'd3, 8'd2);            // kind 2: frequency and pulse width
    measure(hi, lo);
    check("R4 old period high", hi, 1);
    check("R4 old period low", lo, 8);
    measure(hi, lo);
    check("R9 fp high", hi, 3);
    check("R9 fp low", lo, 1);
    load(2'd0, 8'h01, 8'd0, 8'd0);            // kind 0: ignored
    measure(hi, lo);
    measure(hi, lo);
    check("R9 kind0 high", hi, 3);
    check("R9 kind0 low", lo, 1);
    load(2'd3, 8'h01, 8'd3, 8'd2);            // kind 3 with divide
    measure(hi, lo);
    check("R4 before div high", hi, 2);
    check("R4 before div low", lo, 1);
    measure(hi, lo);
    check("R2 div high", hi, 6);
    check("R2 div low", lo, 2);

    // R7: trip
    trip_in = 1'b1;
    #1;
    check("R7 immediate low", int'(pwm_out), 0);
    @(negedge clk);
    check("R10 run drops on trip", int'(run_flag), 0);
    trip_in = 1'b0;
    low_for("R7 latched after release", 6);
    trip_in = 1'b1;
    load(2'd1, 8'h00, 8'd0, 8'd2);
    trip_in = 1'b0;
    low_for("R7 load during trip", 6);
    load(2'd1, 8'h00, 8'd0, 8'd0);
    check("R7 resume high", int'(pwm_out), 1);
    check("R10 run after clear", int'(run_flag), 1);
    measure(hi, lo);
    check("R7 resumed high", hi, 2);
    check("R7 resumed low", lo, 6);

    // R8: power down
    load(2'd3, 8'h04, 8'd2, 8'd0);
    check("R8 run stops", int'(run_flag), 0);
    low_for("R8 idle", 8);
    load(2'd2, 8'h00, 8'd2, 8'd0);
    check("R8 partial no resume", int'(run_flag), 0);
    low_for("R8 idle after partial", 6);
    load(2'd3, 8'h00, 8'd2, 8'd0);
    check("R8 resume", int'(pwm_out), 1);
    measure(hi, lo);
    check("R8 resumed high", hi, 1);
    check("R8 resumed low", lo, 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule